// File: doc/BRIEF.md
# Fixed-Point Instruction Decoder with Read-Port Gating

This block turns one 32-bit fixed-point instruction word into the control bundle an integer backend needs: an internal operation code, the source and destination register numbers, an extended immediate, per-port register-file read requests, and separate controls that say whether the carry flag, the overflow flag or a condition-register field is to be written. It covers the immediate arithmetic, logical and compare forms and a set of register-register arithmetic forms selected through primary opcode 31.

Read requests are raised per instruction, only for the operands that instruction really consumes, so a single-operand form never occupies the second read port and an add-immediate whose source field is zero reads nothing. A mode input, driven from a machine-state bit, enables an extra accelerator instruction group; when it is clear those encodings are treated like any other unknown word. Every output is registered and appears one clock after the input strobe.

Top module: `fxd_decoder`

Bit positions below number the instruction word with bit 31 as the most significant: primary opcode [31:26], target/source-S [25:21], RA [20:16], RB [15:11], OE [10], extended opcode [9:1], record bit [0], immediate [15:0], compare field [25:23]. Operation codes: none 0, add 1, subtract-from 2, negate 3, multiply 4, divide 5, compare 6, and 7, or 8, xor 9, accelerator 10. Carry-input select: none 0, carry flag 1, overflow flag 2.

## Requirements
- R1: Outputs are registered: out_valid equals in_valid of the previous cycle, and while out_valid is low every control, request and field output is zero; reset clears all outputs.
- R2: Opcodes 14, 15 and 7 decode to add, add and multiply with target [25:21], source [20:16], a sign-extended immediate (shifted left 16 for opcode 15), a target write, and no flag, carry or condition-field update.
- R3: For opcodes 14 and 15 a source field of 0 means literal zero, so the RA read request stays low.
- R4: Opcodes 12, 13 (add) and 8 (subtract-from) assert the carry write; opcode 13 also writes condition field 0.
- R5: Under opcode 31, extended codes 266 add, 40 subf, 104 neg, 235 mullw and 491 divw assert the overflow write exactly when bit [10] is set and the condition-field-0 write exactly when bit [0] is set.
- R6: Extended codes 138, 136 and 202 (add-extended, subtract-from-extended, add-to-zero-extended) select the carry flag as carry input and assert the carry write.
- R7: Opcode 31 with bits [8:1] equal to 170 is an add that selects the overflow flag as carry input; with bits [10:9] equal to 0 it writes the carry flag, with 1 it routes carry-out into the overflow flag and does not write the carry flag, with 2 or 3 it is illegal.
- R8: Opcode 11 and opcode 31 with bits [10:1] zero decode to compare, write the condition field given by bits [25:23], write no target register, and opcode 11 carries a sign-extended immediate.
- R9: Opcodes 28/29, 24/25 and 26/27 decode to and, or and xor with source [25:21], target [20:16], a zero-extended immediate (shifted left 16 for the odd opcodes); only 28 and 29 write condition field 0.
- R10: The RB read request is high only for register-register forms that use a second operand; neg and add-to-zero-extended request only RA, and immediate forms never request RB.
- R11: Opcode 4 decodes to the accelerator operation reading RA and RB when in_gpu_en is high, and is illegal when it is low.
- R12: Any unrecognised word raises out_illegal with operation 0, all read requests, write controls and immediate zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| in_gpu_en | input | 1 | Enables the accelerator instruction group |
| out_valid | output | 1 | Decoded bundle valid |
| out_illegal | output | 1 | Word not recognised |
| out_op | output | 4 | Internal operation code |
| out_src_a | output | 5 | First source register number |
| out_src_b | output | 5 | Second source register number |
| out_dst | output | 5 | Target register number |
| out_imm | output | XLEN | Extended immediate |
| out_rd_a | output | 1 | Read request, port A |
| out_rd_b | output | 1 | Read request, port B |
| out_rt_wr | output | 1 | Target register write |
| out_cin_sel | output | 2 | Carry-input source |
| out_ca_wr | output | 1 | Carry flag write |
| out_ov_wr | output | 1 | Overflow flag write |
| out_co_to_ov | output | 1 | Carry-out written into overflow flag |
| out_cr_wr | output | 1 | Condition field write |
| out_cr_field | output | 3 | Condition field index |

## Verification
The decoder is driven with immediate forms whose immediates have the sign bit set, so sign versus zero extension and the 16-bit shift are told apart, and with a zero source field against a non-zero one to separate literal zero from a register read. Register-register forms are run under all four suffix combinations to show the overflow and record controls follow their own bits, and single-operand forms are put beside two-operand forms to expose RB gating. The carry-select forms are tried with every value of the two-bit field, the accelerator opcode with the mode bit both ways, and unused opcodes and extended codes to confirm nothing is requested or written.

// File: rtl/fxd_pkg.sv
package fxd_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int CRF_W   = 3;

    localparam logic [5:0] PO_GPU     = 6'd4;
    localparam logic [5:0] PO_MULLI   = 6'd7;
    localparam logic [5:0] PO_SUBFIC  = 6'd8;
    localparam logic [5:0] PO_CMPI    = 6'd11;
    localparam logic [5:0] PO_ADDIC   = 6'd12;
    localparam logic [5:0] PO_ADDICR  = 6'd13;
    localparam logic [5:0] PO_ADDI    = 6'd14;
    localparam logic [5:0] PO_ADDIS   = 6'd15;
    localparam logic [5:0] PO_ORI     = 6'd24;
    localparam logic [5:0] PO_ORIS    = 6'd25;
    localparam logic [5:0] PO_XORI    = 6'd26;
    localparam logic [5:0] PO_XORIS   = 6'd27;
    localparam logic [5:0] PO_ANDI    = 6'd28;
    localparam logic [5:0] PO_ANDIS   = 6'd29;
    localparam logic [5:0] PO_EXT     = 6'd31;

    localparam logic [8:0] XO_ADD   = 9'd266;
    localparam logic [8:0] XO_SUBF  = 9'd40;
    localparam logic [8:0] XO_NEG   = 9'd104;
    localparam logic [8:0] XO_ADDE  = 9'd138;
    localparam logic [8:0] XO_SUBFE = 9'd136;
    localparam logic [8:0] XO_ADDZE = 9'd202;
    localparam logic [8:0] XO_MULLW = 9'd235;
    localparam logic [8:0] XO_DIVW  = 9'd491;
    localparam logic [7:0] XO_ADDEX = 8'd170;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUBF = 4'd2,
        OP_NEG  = 4'd3,
        OP_MUL  = 4'd4,
        OP_DIV  = 4'd5,
        OP_CMP  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_GPU  = 4'd10
    } fxd_op_e;

    typedef enum logic [1:0] {
        CIN_NONE = 2'd0,
        CIN_CA   = 2'd1,
        CIN_OV   = 2'd2
    } fxd_cin_e;

    typedef enum logic [2:0] {
        IMM_NONE    = 3'd0,
        IMM_SEXT    = 3'd1,
        IMM_SEXT_HI = 3'd2,
        IMM_ZEXT    = 3'd3,
        IMM_ZEXT_HI = 3'd4
    } fxd_imm_e;

    typedef struct packed {
        logic              illegal;
        fxd_op_e           op;
        logic [REG_W-1:0]  src_a;
        logic [REG_W-1:0]  src_b;
        logic [REG_W-1:0]  dst;
        logic              use_a;
        logic              use_b;
        logic              rt_wr;
        fxd_cin_e          cin;
        logic              ca_wr;
        logic              ov_wr;
        logic              co_to_ov;
        logic              cr_wr;
        logic [CRF_W-1:0]  cr_field;
        fxd_imm_e          imm_kind;
    } fxd_ctl_t;

    function automatic logic [5:0] f_opcode(input logic [INSTR_W-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic is_logic_imm(input logic [5:0] po);
        return (po >= PO_ORI) && (po <= PO_ANDIS);
    endfunction

endpackage

// File: rtl/fxd_imm_gen.sv
module fxd_imm_gen
    import fxd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [15:0]     imm16,
    input  fxd_imm_e        kind,
    output logic [XLEN-1:0] imm
);
    localparam int PAD_LO = XLEN - 16;
    localparam int PAD_HI = XLEN - 32;

    always_comb begin
        case (kind)
            IMM_SEXT:    imm = {{PAD_LO{imm16[15]}}, imm16};
            IMM_SEXT_HI: imm = {{PAD_HI{imm16[15]}}, imm16, 16'h0000};
            IMM_ZEXT:    imm = {{PAD_LO{1'b0}}, imm16};
            IMM_ZEXT_HI: imm = {{PAD_HI{1'b0}}, imm16, 16'h0000};
            default:     imm = '0;
        endcase
    end
endmodule

// File: rtl/fxd_opsel.sv
module fxd_opsel
    import fxd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               gpu_en,
    output fxd_ctl_t           ctl
);
    logic [5:0]       po;
    logic [REG_W-1:0] f_rt, f_ra, f_rb;
    logic             f_oe, f_rc;
    logic [8:0]       f_xo9;
    logic [9:0]       f_xo10;
    logic [7:0]       f_xo8;
    logic [1:0]       f_cy;
    logic [CRF_W-1:0] f_bf;

    assign po     = f_opcode(instr);
    assign f_rt   = instr[25:21];
    assign f_ra   = instr[20:16];
    assign f_rb   = instr[15:11];
    assign f_oe   = instr[10];
    assign f_xo9  = instr[9:1];
    assign f_xo10 = instr[10:1];
    assign f_xo8  = instr[8:1];
    assign f_cy   = instr[10:9];
    assign f_rc   = instr[0];
    assign f_bf   = instr[25:23];

    fxd_ctl_t c;
    logic     bad;

    always_comb begin
        c   = '0;
        bad = 1'b0;
        case (po)
            PO_ADDI, PO_ADDIS: begin
                c.op       = OP_ADD;
                c.src_a    = f_ra;
                c.use_a    = (f_ra != '0);
                c.dst      = f_rt;
                c.rt_wr    = 1'b1;
                c.imm_kind = (po == PO_ADDIS) ? IMM_SEXT_HI : IMM_SEXT;
            end
            PO_MULLI: begin
                c.op       = OP_MUL;
                c.src_a    = f_ra;
                c.use_a    = 1'b1;
                c.dst      = f_rt;
                c.rt_wr    = 1'b1;
                c.imm_kind = IMM_SEXT;
            end
            PO_ADDIC, PO_ADDICR, PO_SUBFIC: begin
                c.op       = (po == PO_SUBFIC) ? OP_SUBF : OP_ADD;
                c.src_a    = f_ra;
                c.use_a    = 1'b1;
                c.dst      = f_rt;
                c.rt_wr    = 1'b1;
                c.ca_wr    = 1'b1;
                c.cr_wr    = (po == PO_ADDICR);
                c.imm_kind = IMM_SEXT;
            end
            PO_CMPI: begin
                c.op       = OP_CMP;
                c.src_a    = f_ra;
                c.use_a    = 1'b1;
                c.cr_wr    = 1'b1;
                c.cr_field = f_bf;
                c.imm_kind = IMM_SEXT;
            end
            PO_ORI, PO_ORIS, PO_XORI, PO_XORIS, PO_ANDI, PO_ANDIS: begin
                case (po)
                    PO_ANDI, PO_ANDIS: c.op = OP_AND;
                    PO_ORI,  PO_ORIS:  c.op = OP_OR;
                    default:           c.op = OP_XOR;
                endcase
                c.src_a    = f_rt;
                c.use_a    = 1'b1;
                c.dst      = f_ra;
                c.rt_wr    = 1'b1;
                c.cr_wr    = (po == PO_ANDI) || (po == PO_ANDIS);
                c.imm_kind = po[0] ? IMM_ZEXT_HI : IMM_ZEXT;
            end
            PO_GPU: begin
                if (gpu_en) begin
                    c.op    = OP_GPU;
                    c.src_a = f_ra;
                    c.src_b = f_rb;
                    c.dst   = f_rt;
                    c.use_a = 1'b1;
                    c.use_b = 1'b1;
                    c.rt_wr = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end
            PO_EXT: begin
                c.src_a = f_ra;
                c.use_a = 1'b1;
                if (f_xo10 == '0) begin
                    c.op       = OP_CMP;
                    c.src_b    = f_rb;
                    c.use_b    = 1'b1;
                    c.cr_wr    = 1'b1;
                    c.cr_field = f_bf;
                end else begin
                    c.dst   = f_rt;
                    c.rt_wr = 1'b1;
                    c.use_b = 1'b1;
                    c.ov_wr = f_oe;
                    c.cr_wr = f_rc;
                    case (f_xo9)
                        XO_ADD:   c.op = OP_ADD;
                        XO_SUBF:  c.op = OP_SUBF;
                        XO_MULLW: c.op = OP_MUL;
                        XO_DIVW:  c.op = OP_DIV;
                        XO_NEG: begin
                            c.op    = OP_NEG;
                            c.use_b = 1'b0;
                        end
                        XO_ADDE, XO_SUBFE, XO_ADDZE: begin
                            c.op    = (f_xo9 == XO_SUBFE) ? OP_SUBF : OP_ADD;
                            c.cin   = CIN_CA;
                            c.ca_wr = 1'b1;
                            c.use_b = (f_xo9 != XO_ADDZE);
                        end
                        default: begin
                            c.ov_wr = 1'b0;
                            c.cr_wr = 1'b0;
                            if (f_xo8 == XO_ADDEX && !f_cy[1]) begin
                                c.op       = OP_ADD;
                                c.cin      = CIN_OV;
                                c.ca_wr    = !f_cy[0];
                                c.co_to_ov = f_cy[0];
                            end else begin
                                bad = 1'b1;
                            end
                        end
                    endcase
                end
                if (c.use_b) c.src_b = f_rb;
            end
            default: bad = 1'b1;
        endcase

        if (bad) begin
            c         = '0;
            c.illegal = 1'b1;
        end
        ctl = c;
    end
endmodule

// File: rtl/fxd_port_gate.sv
module fxd_port_gate
    import fxd_pkg::*;
(
    input  logic     valid,
    input  fxd_ctl_t raw,
    output fxd_ctl_t gated,
    output logic     rd_a,
    output logic     rd_b
);
    always_comb begin
        gated = valid ? raw : '0;
        rd_a  = gated.use_a && !gated.illegal;
        rd_b  = gated.use_b && !gated.illegal;
    end
endmodule

// File: rtl/fxd_decoder.sv
module fxd_decoder
    import fxd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic            in_gpu_en,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [3:0]      out_op,
    output logic [4:0]      out_src_a,
    output logic [4:0]      out_src_b,
    output logic [4:0]      out_dst,
    output logic [XLEN-1:0] out_imm,
    output logic            out_rd_a,
    output logic            out_rd_b,
    output logic            out_rt_wr,
    output logic [1:0]      out_cin_sel,
    output logic            out_ca_wr,
    output logic            out_ov_wr,
    output logic            out_co_to_ov,
    output logic            out_cr_wr,
    output logic [2:0]      out_cr_field
);
    fxd_ctl_t        raw_ctl, nxt_ctl, q_ctl;
    logic            nxt_rd_a, nxt_rd_b;
    logic [XLEN-1:0] nxt_imm;
    logic            q_valid, q_rd_a, q_rd_b;
    logic [XLEN-1:0] q_imm;

    fxd_opsel u_opsel (
        .instr  (in_instr),
        .gpu_en (in_gpu_en),
        .ctl    (raw_ctl)
    );

    fxd_port_gate u_gate (
        .valid (in_valid),
        .raw   (raw_ctl),
        .gated (nxt_ctl),
        .rd_a  (nxt_rd_a),
        .rd_b  (nxt_rd_b)
    );

    fxd_imm_gen #(.XLEN(XLEN)) u_imm (
        .imm16 (in_instr[15:0]),
        .kind  (nxt_ctl.imm_kind),
        .imm   (nxt_imm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_ctl   <= '0;
            q_rd_a  <= 1'b0;
            q_rd_b  <= 1'b0;
            q_imm   <= '0;
        end else begin
            q_valid <= in_valid;
            q_ctl   <= nxt_ctl;
            q_rd_a  <= nxt_rd_a;
            q_rd_b  <= nxt_rd_b;
            q_imm   <= nxt_imm;
        end
    end

    assign out_valid    = q_valid;
    assign out_illegal  = q_ctl.illegal;
    assign out_op       = q_ctl.op;
    assign out_src_a    = q_ctl.src_a;
    assign out_src_b    = q_ctl.src_b;
    assign out_dst      = q_ctl.dst;
    assign out_imm      = q_imm;
    assign out_rd_a     = q_rd_a;
    assign out_rd_b     = q_rd_b;
    assign out_rt_wr    = q_ctl.rt_wr;
    assign out_cin_sel  = q_ctl.cin;
    assign out_ca_wr    = q_ctl.ca_wr;
    assign out_ov_wr    = q_ctl.ov_wr;
    assign out_co_to_ov = q_ctl.co_to_ov;
    assign out_cr_wr    = q_ctl.cr_wr;
    assign out_cr_field = q_ctl.cr_field;

    // R1: the strobe reappears exactly one cycle later
    a_r1_valid_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_delay: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R1: nothing requested or written while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_rd_a || out_rd_b || out_rt_wr || out_ca_wr ||
                         out_ov_wr || out_co_to_ov || out_cr_wr || out_illegal));
    // R12: an illegal word leaves every control low
    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> !(out_rd_a || out_rd_b || out_rt_wr || out_ca_wr ||
                          out_ov_wr || out_co_to_ov || out_cr_wr) && out_op == 4'd0);
    // R11: accelerator group is refused while the mode bit is clear
    a_r11_gpu_locked: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_gpu_en && in_instr[31:26] == 6'd4) |=> out_illegal);
    // R10: immediate forms never take port B
    a_r10_imm_no_rb: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[31:26] != 6'd31 && in_instr[31:26] != 6'd4) |=> !out_rd_b);
    // R7: carry-out goes to one flag only
    a_r7_one_carry_dest: assert property (@(posedge clk) disable iff (rst)
        out_co_to_ov |-> !out_ca_wr && out_cin_sel == 2'd2);
    // R8: a compare never writes a target register
    a_r8_cmp_no_wr: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_op == 4'd6) |-> !out_rt_wr && out_cr_wr);
endmodule

// File: tb/fxd_decoder_bench.sv
`timescale 1ns/1ps
module fxd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        in_gpu_en = 1'b0;
    logic        out_valid, out_illegal, out_rd_a, out_rd_b, out_rt_wr;
    logic        out_ca_wr, out_ov_wr, out_co_to_ov, out_cr_wr;
    logic [3:0]  out_op;
    logic [4:0]  out_src_a, out_src_b, out_dst;
    logic [63:0] out_imm;
    logic [1:0]  out_cin_sel;
    logic [2:0]  out_cr_field;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fxd_decoder #(.XLEN(64)) u_fxd_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_gpu_en(in_gpu_en), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_op(out_op), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_dst(out_dst), .out_imm(out_imm), .out_rd_a(out_rd_a),
        .out_rd_b(out_rd_b), .out_rt_wr(out_rt_wr), .out_cin_sel(out_cin_sel),
        .out_ca_wr(out_ca_wr), .out_ov_wr(out_ov_wr), .out_co_to_ov(out_co_to_ov),
        .out_cr_wr(out_cr_wr), .out_cr_field(out_cr_field)
    );

    typedef struct packed {
        logic        vld;
        logic        ill;
        logic [3:0]  op;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [4:0]  d;
        logic [63:0] imm;
        logic        rda;
        logic        rdb;
        logic        wr;
        logic [1:0]  cin;
        logic        ca;
        logic        ov;
        logic        co;
        logic        cr;
        logic [2:0]  crf;
    } exp_t;

    function automatic exp_t actual();
        exp_t r;
        r = '{out_valid, out_illegal, out_op, out_src_a, out_src_b, out_dst, out_imm,
              out_rd_a, out_rd_b, out_rt_wr, out_cin_sel, out_ca_wr, out_ov_wr,
              out_co_to_ov, out_cr_wr, out_cr_field};
        return r;
    endfunction

    function automatic exp_t base(input logic [3:0] op, input logic [4:0] a,
                                  input logic [4:0] b, input logic [4:0] d);
        exp_t e = '0;
        e.vld = 1'b1; e.op = op; e.a = a; e.b = b; e.d = d;
        e.rda = 1'b1; e.wr = 1'b1;
        return e;
    endfunction

    function automatic logic [31:0] d_form(input logic [5:0] po, input logic [4:0] t,
                                           input logic [4:0] s, input logic [15:0] im);
        return {po, t, s, im};
    endfunction

    function automatic logic [31:0] xo_form(input logic [4:0] t, input logic [4:0] a,
                                            input logic [4:0] b, input logic oe,
                                            input logic [8:0] xo, input logic rc);
        return {6'd31, t, a, b, oe, xo, rc};
    endfunction

    task automatic compare(input string tag, input exp_t e);
        exp_t got = actual();
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, e);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic gpu, input string tag,
                         input exp_t e);
        @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = w;
        in_gpu_en = gpu;
        @(negedge clk);
        in_valid  = 1'b0;
        in_instr  = '0;
        compare(tag, e);
    endtask

    task automatic t_reset();
        @(negedge clk);
        compare("R1 reset state", exp_t'(0));
        rst = 1'b0;
    endtask

    task automatic t_imm_arith();
        exp_t e;
        e = base(4'd1, 5'd3, 5'd0, 5'd9); e.imm = 64'hFFFF_FFFF_FFFF_FFF0;
        drive(d_form(6'd14, 5'd9, 5'd3, 16'hFFF0), 1'b0, "R2 addi sign ext", e);
        e = base(4'd1, 5'd4, 5'd0, 5'd2); e.imm = 64'hFFFF_FFFF_8001_0000;
        drive(d_form(6'd15, 5'd2, 5'd4, 16'h8001), 1'b0, "R2 addis shifted", e);
        e = base(4'd4, 5'd7, 5'd0, 5'd1); e.imm = 64'h0000_0000_0000_1234;
        drive(d_form(6'd7, 5'd1, 5'd7, 16'h1234), 1'b0, "R2 mulli", e);
        e = base(4'd1, 5'd0, 5'd0, 5'd5); e.rda = 1'b0; e.imm = 64'd8;
        drive(d_form(6'd14, 5'd5, 5'd0, 16'd8), 1'b0, "R3 addi ra zero no read", e);
        e = base(4'd1, 5'd0, 5'd0, 5'd6); e.rda = 1'b0; e.imm = 64'h0000_0000_0001_0000;
        drive(d_form(6'd15, 5'd6, 5'd0, 16'd1), 1'b0, "R3 addis ra zero no read", e);
    endtask

    task automatic t_carry_imm();
        exp_t e;
        e = base(4'd1, 5'd8, 5'd0, 5'd10); e.ca = 1'b1; e.imm = 64'hFFFF_FFFF_FFFF_FFFF;
        drive(d_form(6'd12, 5'd10, 5'd8, 16'hFFFF), 1'b0, "R4 addic carry", e);
        e = base(4'd1, 5'd8, 5'd0, 5'd10); e.ca = 1'b1; e.cr = 1'b1; e.imm = 64'd5;
        drive(d_form(6'd13, 5'd10, 5'd8, 16'd5), 1'b0, "R4 addic. carry cr0", e);
        e = base(4'd2, 5'd0, 5'd0, 5'd11); e.ca = 1'b1; e.imm = 64'd3;
        drive(d_form(6'd8, 5'd11, 5'd0, 16'd3), 1'b0, "R4 subfic carry", e);
    endtask

    task automatic t_xo_suffix();
        exp_t e;
        for (int k = 0; k < 4; k++) begin
            e = base(4'd1, 5'd1, 5'd2, 5'd3); e.rdb = 1'b1;
            e.ov = k[1]; e.cr = k[0];
            drive(xo_form(5'd3, 5'd1, 5'd2, k[1], 9'd266, k[0]), 1'b0,
                  "R5 add suffix combo", e);
        end
        e = base(4'd2, 5'd4, 5'd5, 5'd6); e.rdb = 1'b1; e.ov = 1'b1;
        drive(xo_form(5'd6, 5'd4, 5'd5, 1'b1, 9'd40, 1'b0), 1'b0, "R5 subfo", e);
        e = base(4'd4, 5'd4, 5'd5, 5'd6); e.rdb = 1'b1; e.cr = 1'b1;
        drive(xo_form(5'd6, 5'd4, 5'd5, 1'b0, 9'd235, 1'b1), 1'b0, "R5 mullw.", e);
        e = base(4'd5, 5'd4, 5'd5, 5'd6); e.rdb = 1'b1; e.ov = 1'b1; e.cr = 1'b1;
        drive(xo_form(5'd6, 5'd4, 5'd5, 1'b1, 9'd491, 1'b1), 1'b0, "R5 divwo.", e);
        e = base(4'd3, 5'd12, 5'd0, 5'd13); e.ov = 1'b1;
        drive(xo_form(5'd13, 5'd12, 5'd9, 1'b1, 9'd104, 1'b0), 1'b0, "R10 neg only RA", e);
    endtask

    task automatic t_extended();
        exp_t e;
        e = base(4'd1, 5'd1, 5'd2, 5'd3); e.rdb = 1'b1; e.cin = 2'd1; e.ca = 1'b1;
        drive(xo_form(5'd3, 5'd1, 5'd2, 1'b0, 9'd138, 1'b0), 1'b0, "R6 adde", e);
        e = base(4'd2, 5'd1, 5'd2, 5'd3); e.rdb = 1'b1; e.cin = 2'd1; e.ca = 1'b1; e.cr = 1'b1;
        drive(xo_form(5'd3, 5'd1, 5'd2, 1'b0, 9'd136, 1'b1), 1'b0, "R6 subfe.", e);
        e = base(4'd1, 5'd1, 5'd0, 5'd3); e.cin = 2'd1; e.ca = 1'b1;
        drive(xo_form(5'd3, 5'd1, 5'd7, 1'b0, 9'd202, 1'b0), 1'b0, "R10 addze only RA", e);
    endtask

    task automatic t_addex();
        exp_t e;
        e = base(4'd1, 5'd1, 5'd2, 5'd3); e.rdb = 1'b1; e.cin = 2'd2; e.ca = 1'b1;
        drive({6'd31, 5'd3, 5'd1, 5'd2, 2'd0, 8'd170, 1'b0}, 1'b0, "R7 addex cy0", e);
        e = base(4'd1, 5'd1, 5'd2, 5'd3); e.rdb = 1'b1; e.cin = 2'd2; e.co = 1'b1;
        drive({6'd31, 5'd3, 5'd1, 5'd2, 2'd1, 8'd170, 1'b0}, 1'b0, "R7 addex cy1", e);
        for (int k = 2; k < 4; k++) begin
            e = '0; e.vld = 1'b1; e.ill = 1'b1;
            drive({6'd31, 5'd3, 5'd1, 5'd2, 2'(k), 8'd170, 1'b0}, 1'b0,
                  "R7 addex reserved cy", e);
        end
    endtask

    task automatic t_compare();
        exp_t e;
        e = base(4'd6, 5'd4, 5'd0, 5'd0); e.wr = 1'b0; e.cr = 1'b1; e.crf = 3'd5;
        e.imm = 64'hFFFF_FFFF_FFFF_FFFE;
        drive(d_form(6'd11, {3'd5, 2'd0}, 5'd4, 16'hFFFE), 1'b0, "R8 cmpi field 5", e);
        e = base(4'd6, 5'd4, 5'd8, 5'd0); e.wr = 1'b0; e.rdb = 1'b1; e.cr = 1'b1; e.crf = 3'd7;
        drive({6'd31, 3'd7, 2'd0, 5'd4, 5'd8, 10'd0, 1'b0}, 1'b0, "R8 cmp field 7", e);
    endtask

    task automatic t_logical();
        exp_t e;
        e = base(4'd7, 5'd2, 5'd0, 5'd9); e.cr = 1'b1; e.imm = 64'h0000_0000_0000_8001;
        drive(d_form(6'd28, 5'd2, 5'd9, 16'h8001), 1'b0, "R9 andi. zext cr0", e);
        e = base(4'd7, 5'd2, 5'd0, 5'd9); e.cr = 1'b1; e.imm = 64'h0000_0000_8001_0000;
        drive(d_form(6'd29, 5'd2, 5'd9, 16'h8001), 1'b0, "R9 andis. shifted", e);
        e = base(4'd8, 5'd2, 5'd0, 5'd9); e.imm = 64'h0000_0000_0000_F00F;
        drive(d_form(6'd24, 5'd2, 5'd9, 16'hF00F), 1'b0, "R9 ori no cr", e);
        e = base(4'd9, 5'd2, 5'd0, 5'd9); e.imm = 64'h0000_0000_FFFF_0000;
        drive(d_form(6'd27, 5'd2, 5'd9, 16'hFFFF), 1'b0, "R9 xoris no cr", e);
    endtask

    task automatic t_gpu();
        exp_t e;
        e = base(4'd10, 5'd1, 5'd2, 5'd3); e.rdb = 1'b1;
        drive({6'd4, 5'd3, 5'd1, 5'd2, 11'd0}, 1'b1, "R11 gpu enabled", e);
        e = '0; e.vld = 1'b1; e.ill = 1'b1;
        drive({6'd4, 5'd3, 5'd1, 5'd2, 11'd0}, 1'b0, "R11 gpu disabled illegal", e);
    endtask

    task automatic t_illegal();
        exp_t e;
        e = '0; e.vld = 1'b1; e.ill = 1'b1;
        drive(d_form(6'd0, 5'd1, 5'd2, 16'h7FFF), 1'b1, "R12 opcode 0", e);
        drive(d_form(6'd32, 5'd1, 5'd2, 16'h0001), 1'b1, "R12 opcode 32", e);
        drive(xo_form(5'd3, 5'd1, 5'd2, 1'b0, 9'd300, 1'b1), 1'b1, "R12 unknown xo", e);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_instr = d_form(6'd14, 5'd1, 5'd2, 16'd1);
        @(negedge clk);
        compare("R1 no strobe no output", exp_t'(0));
        in_instr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_imm_arith();
        t_carry_imm();
        t_xo_suffix();
        t_extended();
        t_addex();
        t_compare();
        t_logical();
        t_gpu();
        t_illegal();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule